// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software from a slow clock domain. A 12-bit down-counter steps once per tick enable, which is nominally 256 Hz. Software must restart the counter inside a window. A restart that arrives while the counter is still above the window threshold is a fault. Letting the counter run down to zero is also a fault. Each fault can raise a level interrupt, a one-cycle reset request, or both. It also sets a sticky status flag that is cleared by reading the status register.

Configuration lives in a mode register that accepts one write after reset and is locked from then on. Restart commands must carry a fixed key, so a stray write cannot feed the watchdog. Two halt inputs, one for idle and one for debug, can each freeze the counter when the mode register enables them.

The register bus is a plain single-cycle bus with write enable, read strobe, word address, write data and combinational read data. There are three word addresses:
- 0 is the control register (write only).
- 1 is the mode register.
- 2 is the status register.

Top module: `wdog_win`

## Requirements
- R1: After reset the mode register reads 0x3FFF2FFF. The status register reads 0, irq_o and rst_req_o are low, and the counter holds 0xFFF.
- R2: The first write to address 1 after reset is stored, with bits 31:30 read back as zero. Every later write to address 1 is ignored until the next reset.
- R3: A write to address 0 restarts the counter only when bits 31:24 equal 0xA5 and bit 0 is 1. Any other control write has no effect.
- R4: Each tick on a running counter decrements it. A tick that finds the counter at 1 or 0 is an underflow fault and reloads the counter from mode bits 11:0. So with reload value V ≥ 1, the fault comes on the V-th tick after a reload. An accepted mode write also reloads the counter.
- R5: A valid restart while the counter exceeds mode bits 27:16 is an early-restart fault. A restart at or below that threshold is not a fault. Both cases reload the counter from bits 11:0.
- R6: irq_o is high while any status flag is set and mode bit 12 is 1. rst_req_o pulses high for exactly the cycle after each fault edge when mode bit 13 is 1.
- R7: Address 2 reads underflow in bit 0 and early restart in bit 1. A read with re_i clears both flags. A fault in the same cycle as that read wins over the clear.
- R8: While mode bit 29 and idle_i are both 1, or mode bit 28 and dbg_i are both 1, ticks do not change the counter.
- R9: While mode bit 15 is 1, ticks do not change the counter and no fault of either kind is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable, one cycle per tick |
| idle_i | input | 1 | System idle indication |
| dbg_i | input | 1 | Debugger halt indication |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Fault interrupt, level |
| rst_req_o | output | 1 | Fault reset request, one-cycle pulse |

## Verification
Directed sequences count ticks to the exact underflow cycle. They then place restarts on both sides of the window threshold, which separates an early fault from a clean feed. A wrong-key write is placed at a point where a real restart would have faulted, so the absence of the pulse together with the unchanged underflow time shows the write was ignored. Halted ticks are interleaved with live ticks, so a counter that moves while halted shifts the underflow cycle. Separate resets cover the disabled mode and the configuration with the reset request but no interrupt. A random phase then mixes ticks (some halted), good and bad restarts and status reads against a bench model of counter and flags, which exposes errors in priority and in the clear-on-read ordering.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int DW = 32;
  localparam int AW = 2;
  localparam int CW = 12;
  localparam int KW = 8;

  localparam logic [DW-1:0] MODE_RST  = 32'h3FFF_2FFF;
  localparam logic [DW-1:0] MODE_MASK = 32'h3FFF_FFFF;
  localparam logic [KW-1:0] CTRL_KEY  = 8'hA5;

  localparam logic [AW-1:0] A_CTRL = 2'd0;
  localparam logic [AW-1:0] A_MODE = 2'd1;
  localparam logic [AW-1:0] A_STAT = 2'd2;

  localparam int B_FIEN  = 12;
  localparam int B_RSTEN = 13;
  localparam int B_DIS   = 15;
  localparam int B_DBGH  = 28;
  localparam int B_IDLEH = 29;
  localparam int DLT_LSB = 16;
endpackage

// File: rtl/wdog_mode_reg.sv
`timescale 1ns/1ps
module wdog_mode_reg #(
  parameter int              DW   = 32,
  parameter logic [DW-1:0]   RST  = '0,
  parameter logic [DW-1:0]   MASK = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mode_o,
  output logic          load_o
);
  logic          locked_q;
  logic [DW-1:0] mode_q;

  assign load_o = wr_i & ~locked_q;
  assign mode_o = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= RST;
      locked_q <= 1'b0;
    end else if (load_o) begin
      mode_q   <= wdata_i & MASK;
      locked_q <= 1'b1;
    end
  end

  p_lock_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && wr_i) |=> $stable(mode_q))
    else $error("mode register changed after lock");
endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          halt_i,
  input  logic          dis_i,
  input  logic          restart_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic [CW-1:0] value_i,
  input  logic [CW-1:0] delta_i,
  output logic          unf_o,
  output logic          early_o
);
  localparam logic [CW-1:0] CNT_RST = '1;
  localparam logic [CW-1:0] ONE     = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;

  // mode load beats restart beats tick
  always_comb begin
    cnt_d   = cnt_q;
    unf_o   = 1'b0;
    early_o = 1'b0;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (restart_i) begin
      cnt_d   = value_i;
      early_o = ~dis_i & (cnt_q > delta_i);
    end else if (tick_i && !dis_i && !halt_i) begin
      if (cnt_q <= ONE) begin
        unf_o = 1'b1;
        cnt_d = value_i;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CNT_RST;
    else         cnt_q <= cnt_d;
  end

  p_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !restart_i && (halt_i || dis_i)) |=> $stable(cnt_q))
    else $error("counter moved while halted or disabled");

  p_cnt_le_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= value_i)
    else $error("counter above reload value");
endmodule

// File: rtl/wdog_fault.sv
`timescale 1ns/1ps
module wdog_fault (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       unf_i,
  input  logic       early_i,
  input  logic       clr_i,
  input  logic       dis_i,
  input  logic       fien_i,
  input  logic       rsten_i,
  output logic [1:0] flags_o,
  output logic       irq_o,
  output logic       rst_req_o
);
  logic unf_q, err_q, req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unf_q <= 1'b0;
      err_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      // a new fault wins over the read clear
      unf_q <= unf_i   | (unf_q & ~clr_i);
      err_q <= early_i | (err_q & ~clr_i);
      req_q <= rsten_i & (unf_i | early_i);
    end
  end

  assign flags_o   = {err_q, unf_q};
  assign irq_o     = fien_i & (unf_q | err_q);
  assign rst_req_o = req_q;

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unf_i && clr_i) |=> unf_q)
    else $error("underflow flag lost to clear");

  p_req_has_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (unf_q || err_q))
    else $error("reset request without a fault flag");

  p_dis_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |-> !(unf_i || early_i))
    else $error("fault raised while disabled");
endmodule

// File: rtl/wdog_win.sv
`timescale 1ns/1ps
module wdog_win
  import wdog_pkg::*;
#(
  parameter int AWP = AW,
  parameter int DWP = DW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           idle_i,
  input  logic           dbg_i,
  input  logic           we_i,
  input  logic           re_i,
  input  logic [AWP-1:0] addr_i,
  input  logic [DWP-1:0] wdata_i,
  output logic [DWP-1:0] rdata_o,
  output logic           irq_o,
  output logic           rst_req_o
);
  logic [DWP-1:0] mode;
  logic           mode_load;
  logic           restart, unf, early, halt, clr;
  logic [1:0]     flags;

  wdog_mode_reg #(.DW(DWP), .RST(MODE_RST), .MASK(MODE_MASK)) u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (we_i && addr_i == AWP'(A_MODE)),
    .wdata_i (wdata_i),
    .mode_o  (mode),
    .load_o  (mode_load)
  );

  assign restart = we_i && addr_i == AWP'(A_CTRL)
                   && wdata_i[DWP-1 -: KW] == CTRL_KEY && wdata_i[0];
  assign halt    = (mode[B_IDLEH] & idle_i) | (mode[B_DBGH] & dbg_i);
  assign clr     = re_i && addr_i == AWP'(A_STAT);

  wdog_counter #(.CW(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .halt_i     (halt),
    .dis_i      (mode[B_DIS]),
    .restart_i  (restart),
    .load_i     (mode_load),
    .load_val_i (wdata_i[CW-1:0]),
    .value_i    (mode[CW-1:0]),
    .delta_i    (mode[DLT_LSB +: CW]),
    .unf_o      (unf),
    .early_o    (early)
  );

  wdog_fault u_flt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .unf_i     (unf),
    .early_i   (early),
    .clr_i     (clr),
    .dis_i     (mode[B_DIS]),
    .fien_i    (mode[B_FIEN]),
    .rsten_i   (mode[B_RSTEN]),
    .flags_o   (flags),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );

  always_comb begin
    unique case (addr_i)
      AWP'(A_MODE): rdata_o = mode;
      AWP'(A_STAT): rdata_o = {{(DWP-2){1'b0}}, flags};
      default:      rdata_o = '0;
    endcase
  end
endmodule

// File: tb/sim_wdog_win.sv
`timescale 1ns/1ps
module sim_wdog_win;
  import wdog_pkg::*;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tick = 1'b0, idle = 1'b0, dbg = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rstreq;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  wdog_win u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .idle_i(idle), .dbg_i(dbg),
    .we_i(we), .re_i(re), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .rst_req_o(rstreq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    re = 1'b1; addr = a;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    re = 1'b0;
  endtask

  task automatic tk(bit i, bit g);
    idle = i; dbg = g; tick = 1'b1;
    @(posedge clk); @(negedge clk);
    tick = 1'b0; idle = 1'b0; dbg = 1'b0;
  endtask

  // bench model: {fault, next count}
  function automatic logic [12:0] model_tick(logic [11:0] c, logic [11:0] v);
    if (c <= 12'd1) return {1'b1, v};
    return {1'b0, c - 12'd1};
  endfunction

  function automatic logic model_early(logic [11:0] c, logic [11:0] d);
    return c > d;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic [11:0] mc, v, dl;
    logic [12:0] r;
    bit mu, me, exp_rst;
    void'($urandom(32'd2024));

    // ---- session A ----
    do_reset();
    chk("R1 rst_req", {31'b0, rstreq}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    rd(A_MODE, d); chk("R1 mode reset", d, 32'h3FFF_2FFF);
    rd(A_STAT, d); chk("R1 status reset", d, 0);
    wr(A_MODE, 32'hF004_300A);
    rd(A_MODE, d); chk("R2 first write", d, 32'h3004_300A);
    wr(A_MODE, 32'h0000_8005);
    rd(A_MODE, d); chk("R2 second write ignored", d, 32'h3004_300A);
    for (int k = 0; k < 9; k++) begin
      tk(0, 0); chk("R4 no early underflow", {31'b0, rstreq}, 0);
    end
    tk(0, 0);
    chk("R4 underflow on 10th tick", {31'b0, rstreq}, 1);
    chk("R6 irq on fault", {31'b0, irq}, 1);
    tk(0, 0);
    chk("R6 reset request one cycle", {31'b0, rstreq}, 0);
    rd(A_STAT, d); chk("R7 underflow flag", d, 1);
    rd(A_STAT, d); chk("R7 cleared on read", d, 0);
    chk("R6 irq drops after clear", {31'b0, irq}, 0);
    wr(A_CTRL, 32'hA500_0001);          // count 9 > 4
    chk("R5 early restart pulse", {31'b0, rstreq}, 1);
    rd(A_STAT, d); chk("R5 early flag", d, 2);
    repeat (3) tk(0, 0);                // count 7
    wr(A_CTRL, 32'h5A00_0001);
    chk("R3 bad key no fault", {31'b0, rstreq}, 0);
    wr(A_CTRL, 32'hA500_0000);
    chk("R3 missing restart bit no fault", {31'b0, rstreq}, 0);
    repeat (6) tk(0, 0);
    chk("R3 counter not reloaded yet", {31'b0, rstreq}, 0);
    tk(0, 0);
    chk("R3 underflow at unchanged time", {31'b0, rstreq}, 1);
    rd(A_STAT, d); chk("R3 only underflow flag", d, 1);
    repeat (6) tk(0, 0);                // count 4
    wr(A_CTRL, 32'hA500_0001);
    chk("R5 restart inside window", {31'b0, rstreq}, 0);
    rd(A_STAT, d); chk("R5 no flag inside window", d, 0);
    repeat (5) tk(1, 0);
    repeat (5) tk(0, 1);
    repeat (9) tk(0, 0);
    chk("R8 halted ticks not counted", {31'b0, rstreq}, 0);
    tk(0, 0);
    chk("R8 underflow after live ticks", {31'b0, rstreq}, 1);
    rd(A_STAT, d);

    // ---- session B: disabled ----
    do_reset();
    wr(A_MODE, 32'h0000_B003);
    repeat (10) tk(0, 0);
    chk("R9 no underflow when disabled", {31'b0, rstreq}, 0);
    wr(A_CTRL, 32'hA500_0001);
    chk("R9 no early fault when disabled", {31'b0, rstreq}, 0);
    rd(A_STAT, d); chk("R9 status clean", d, 0);
    chk("R9 irq low", {31'b0, irq}, 0);

    // ---- session C: reset request only ----
    do_reset();
    wr(A_MODE, 32'h0000_2002);
    tk(0, 0);
    chk("R4 value 2 first tick quiet", {31'b0, rstreq}, 0);
    tk(0, 0);
    chk("R6 reset request without irq", {31'b0, rstreq}, 1);
    chk("R6 irq masked", {31'b0, irq}, 0);
    rd(A_STAT, d); chk("R7 flag set with irq masked", d, 1);

    // ---- session D: random ----
    do_reset();
    v  = 12'(4 + $urandom % 13);
    dl = 12'($urandom % (v + 1));
    wr(A_MODE, 32'h3000_3000 | (32'(dl) << 16) | 32'(v));
    mc = v; mu = 0; me = 0;
    for (int i = 0; i < 400; i++) begin
      int op = $urandom % 10;
      exp_rst = 0;
      if (op < 6) begin
        bit h = ($urandom % 4) == 0;
        tk(h, 0);
        if (!h) begin
          r = model_tick(mc, v); mc = r[11:0];
          if (r[12]) begin mu = 1; exp_rst = 1; end
        end
      end else if (op == 6) begin
        wr(A_CTRL, 32'hA500_0001);
        if (model_early(mc, dl)) begin me = 1; exp_rst = 1; end
        mc = v;
      end else if (op == 7) begin
        logic [7:0] key = 8'($urandom);
        if (key == 8'hA5) key = 8'h00;
        wr(A_CTRL, {key, 24'h1});
      end else begin
        rd(A_STAT, d);
        chk("R7 random status", d, {30'b0, me, mu});
        mu = 0; me = 0;
      end
      chk("R6 random rst_req", {31'b0, rstreq}, {31'b0, exp_rst});
      chk("R6 random irq", {31'b0, irq}, {31'b0, mu | me});
    end

    summary();
  end
endmodule